// File: doc/BRIEF.md
# Fast Ethernet PHY MAC-side port adapter

This block sits between the core of a Fast Ethernet PHY and the MAC. On the receive side it takes decoded nibbles from the core, or raw five-bit line symbols when the block code is bypassed. It also takes packet start and end strobes, a per-nibble error flag, a clock-recovered flag for 10 Mbit/s reception, a collision flag and the link status. From these it drives the receive data, data-valid, receive-error, carrier-sense and collision outputs toward the MAC. On the transmit side it takes the MAC's data, enable and error inputs and hands an encoder-ready word onward.

Two mode inputs pick the speed and request codec bypass. A bypass request at 100 Mbit/s switches the port into a five-bit symbol mode. In that mode the error lines become the fifth data bit, and the framing outputs carry no meaning. Every register in the block is clocked on the falling edge of the port clock, and a mode change is taken up only while the receiver is idle.

Top module: `phy_mac_port`

## Requirements
- R1: While no packet is being received in nibble mode, `rxd` is 0 and `crs` and `rx_dv` are low.
- R2: A falling edge that samples `link_up` low leaves `crs` and `rx_dv` low, whatever the start, lock or data inputs show.
- R3: At 100 Mbit/s, `rx_er` is high after exactly those falling edges at which `rx_err` was sampled together with a nibble that is put on `rxd`. It is high for that one cycle only.
- R4: At 10 Mbit/s, `rx_er` stays low and `tx_er` has no effect, so `enc_err` stays low.
- R5: At 10 Mbit/s, a start raises `crs` alone. `rx_dv` and data on `rxd` follow only from the falling edge that samples `rx_lock` high.
- R6: Bypass at 100 Mbit/s selects five-bit mode. `rxd` carries `rx_sym[3:0]` and `rx_er` carries `rx_sym[4]` unchanged. `enc_data[3:0]` is `tx_data` and `enc_data[4]` is `tx_er`.
- R7: In five-bit mode, `crs` follows `link_up` only, `rxd`/`rx_er` are 0 on link fail, `tx_en` is ignored (`enc_valid` is 1), and `rx_dv`, `col` and `enc_err` are 0.
- R8: A bypass request at 10 Mbit/s keeps nibble operation.
- R9: In nibble mode, `col` shows the `rx_coll` value sampled at the previous falling edge.
- R10: Speed and bypass inputs are taken up only while the receiver is idle. A packet in progress finishes in the mode in which it started.
- R11: The falling edge that samples `rx_end` drops `crs`, `rx_dv`, `rx_er` and returns `rxd` to 0 together.
- R12: A falling edge that samples `rst_n` low drives every output to 0 and returns the mode to 100 Mbit/s nibble.
- R13: At 100 Mbit/s nibble mode, the start edge already presents `rx_sym[3:0]` with `rx_dv` and `crs` high. The transmit side gives `enc_valid`=`tx_en`, `enc_data`={0,`tx_data`} when enabled (else 0), and `enc_err`=`tx_en`&`tx_er`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all registers use its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_slow | input | 1 | 1 selects 10 Mbit/s operation |
| sel_bypass | input | 1 | 1 requests codec bypass (five-bit mode) |
| link_up | input | 1 | Link pass status from the core |
| rx_start | input | 1 | Start of packet seen by the core |
| rx_end | input | 1 | End of packet seen by the core |
| rx_err | input | 1 | Error flag for the current nibble |
| rx_lock | input | 1 | 10 Mbit/s receive clock recovered |
| rx_coll | input | 1 | Collision condition from the core |
| rx_sym | input | NIB_W+1 | Nibble (low bits) or raw symbol from the core |
| tx_data | input | NIB_W | Transmit data from the MAC |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error, or symbol bit 4 in five-bit mode |
| rxd | output | NIB_W | Receive data to the MAC |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error, or symbol bit 4 in five-bit mode |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| enc_data | output | NIB_W+1 | Word handed to the encoder |
| enc_valid | output | 1 | Encoder word valid |
| enc_err | output | 1 | Transmit error toward the encoder |

## Verification
A 100 Mbit/s packet with an error on one middle nibble separates a one-cycle error mark from a sticky one. It also shows that the start edge already carries data. A 10 Mbit/s packet with delayed lock, and a speed change requested mid-packet, separates carrier from data-valid timing and shows whether the mode switch waits for idle. Five-bit patterns with bit 4 set, an asserted collision flag and a dropped link show whether symbols pass untouched and framing stays silent. A bypass request at 10 Mbit/s, a link loss mid-packet and a reset mid-packet cover the fallback and gating paths.

// File: rtl/mfa_pkg.sv
// Shared types of the MAC-side port adapter.
package mfa_pkg;

    // Receive sequencer states.
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,   // no packet, outputs quiet
        RX_LOCK = 2'd1,   // 10 Mbit/s carrier seen, waiting for clock recovery
        RX_DATA = 2'd2    // nibbles flowing to the MAC
    } rx_state_e;

    // Operating mode applied to the data paths.
    typedef struct packed {
        logic slow;  // 10 Mbit/s
        logic five;  // five-bit symbol pass-through
    } port_mode_t;

endpackage

// File: rtl/mfa_mode_ctl.sv
// Mode control: turns the speed and bypass requests into the mode the data
// paths use. Five-bit mode is refused at 10 Mbit/s. A new request is taken
// up only while the receiver reports idle; otherwise the held mode stays.
// Assumes: rx_idle comes from a register of the receive path.
module mfa_mode_ctl
    import mfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_idle,
    input  logic       sel_slow,
    input  logic       sel_bypass,
    output port_mode_t mode_now,
    output port_mode_t mode_q
);

    port_mode_t req;

    // Legal mode from the request pins; bypass falls back at low speed.
    always_comb begin
        req.slow = sel_slow;
        req.five = sel_bypass & ~sel_slow;
    end

    // Mode used at this edge: the request when idle, the held one otherwise.
    always_comb begin
        mode_now = rx_idle ? req : mode_q;
    end

    // Hold the applied mode; reset returns to 100 Mbit/s nibble mode.
    always_ff @(negedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_now;
    end

endmodule

// File: rtl/mfa_rx_path.sv
// Receive path: sequences a packet from the core toward the MAC and gates
// the outputs by mode and link state. All outputs are registered on the
// falling clock edge. In five-bit mode the sequencer stays idle and
// symbols pass straight through. Assumes rx_start/rx_end are one-cycle
// strobes and rx_end is not raised on the start cycle.
module mfa_rx_path
    import mfa_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  port_mode_t       mode_now,
    input  logic             link_up,
    input  logic             rx_start,
    input  logic             rx_end,
    input  logic             rx_err,
    input  logic             rx_lock,
    input  logic             rx_coll,
    input  logic [NIB_W:0]   rx_sym,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             crs,
    output logic             col,
    output logic             rx_idle
);

    rx_state_e        st_q, st_n;
    logic [NIB_W-1:0] rxd_n;
    logic             dv_n, er_n, crs_n, col_n;
    logic [NIB_W-1:0] nib;
    logic             sym_top;

    assign nib     = rx_sym[NIB_W-1:0];
    assign sym_top = rx_sym[NIB_W];

    // Next state and next output values for the coming falling edge.
    always_comb begin
        st_n  = st_q;
        rxd_n = '0;
        dv_n  = 1'b0;
        er_n  = 1'b0;
        crs_n = 1'b0;
        col_n = 1'b0;
        if (mode_now.five) begin
            st_n  = RX_IDLE;
            crs_n = link_up;
            if (link_up) begin
                rxd_n = nib;
                er_n  = sym_top;
            end
        end else begin
            col_n = rx_coll;
            if (!link_up) begin
                st_n = RX_IDLE;
            end else begin
                unique case (st_q)
                    RX_IDLE: begin
                        if (rx_start) begin
                            if (mode_now.slow && !rx_lock) begin
                                st_n  = RX_LOCK;
                                crs_n = 1'b1;
                            end else begin
                                st_n  = RX_DATA;
                                crs_n = 1'b1;
                                dv_n  = 1'b1;
                                rxd_n = nib;
                                er_n  = rx_err & ~mode_now.slow;
                            end
                        end
                    end
                    RX_LOCK: begin
                        if (rx_end) begin
                            st_n = RX_IDLE;
                        end else if (rx_lock) begin
                            st_n  = RX_DATA;
                            crs_n = 1'b1;
                            dv_n  = 1'b1;
                            rxd_n = nib;
                        end else begin
                            crs_n = 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (rx_end) begin
                            st_n = RX_IDLE;
                        end else begin
                            crs_n = 1'b1;
                            dv_n  = 1'b1;
                            rxd_n = nib;
                            er_n  = rx_err & ~mode_now.slow;
                        end
                    end
                    default: st_n = RX_IDLE;
                endcase
            end
        end
    end

    // Register state and outputs on the falling edge; reset clears all.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            rxd   <= '0;
            rx_dv <= 1'b0;
            rx_er <= 1'b0;
            crs   <= 1'b0;
            col   <= 1'b0;
        end else begin
            st_q  <= st_n;
            rxd   <= rxd_n;
            rx_dv <= dv_n;
            rx_er <= er_n;
            crs   <= crs_n;
            col   <= col_n;
        end
    end

    // Idle flag for the mode control.
    assign rx_idle = (st_q == RX_IDLE);

endmodule

// File: rtl/mfa_tx_path.sv
// Transmit path: forms the word for the encoder from the MAC inputs.
// Nibble mode forwards data under the enable and drops the error flag at
// 10 Mbit/s; five-bit mode ignores the enable and uses the error line as
// symbol bit 4. Registered on the falling clock edge like the receive side.
module mfa_tx_path
    import mfa_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  port_mode_t       mode_now,
    input  logic [NIB_W-1:0] tx_data,
    input  logic             tx_en,
    input  logic             tx_er,
    output logic [NIB_W:0]   enc_data,
    output logic             enc_valid,
    output logic             enc_err
);

    logic [NIB_W:0] data_n;
    logic           valid_n, err_n;

    // Select the encoder word by mode.
    always_comb begin
        if (mode_now.five) begin
            data_n  = {tx_er, tx_data};
            valid_n = 1'b1;
            err_n   = 1'b0;
        end else begin
            data_n  = tx_en ? {1'b0, tx_data} : '0;
            valid_n = tx_en;
            err_n   = tx_en & tx_er & ~mode_now.slow;
        end
    end

    // Register the encoder word; reset clears it.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            enc_data  <= '0;
            enc_valid <= 1'b0;
            enc_err   <= 1'b0;
        end else begin
            enc_data  <= data_n;
            enc_valid <= valid_n;
            enc_err   <= err_n;
        end
    end

endmodule

// File: rtl/phy_mac_port.sv
// MAC-side port adapter of a Fast Ethernet PHY: mode control, receive
// path and transmit path sharing one clock, all registered on its falling
// edge. Assumes the core's inputs change away from the falling edge.
module phy_mac_port
    import mfa_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_slow,
    input  logic             sel_bypass,
    input  logic             link_up,
    input  logic             rx_start,
    input  logic             rx_end,
    input  logic             rx_err,
    input  logic             rx_lock,
    input  logic             rx_coll,
    input  logic [NIB_W:0]   rx_sym,
    input  logic [NIB_W-1:0] tx_data,
    input  logic             tx_en,
    input  logic             tx_er,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             crs,
    output logic             col,
    output logic [NIB_W:0]   enc_data,
    output logic             enc_valid,
    output logic             enc_err
);

    port_mode_t mode_now, mode_q;
    logic       rx_idle;
    logic       slow_q, five_q;

    assign slow_q = mode_q.slow;
    assign five_q = mode_q.five;

    mfa_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_idle    (rx_idle),
        .sel_slow   (sel_slow),
        .sel_bypass (sel_bypass),
        .mode_now   (mode_now),
        .mode_q     (mode_q)
    );

    mfa_rx_path #(.NIB_W(NIB_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_now (mode_now),
        .link_up  (link_up),
        .rx_start (rx_start),
        .rx_end   (rx_end),
        .rx_err   (rx_err),
        .rx_lock  (rx_lock),
        .rx_coll  (rx_coll),
        .rx_sym   (rx_sym),
        .rxd      (rxd),
        .rx_dv    (rx_dv),
        .rx_er    (rx_er),
        .crs      (crs),
        .col      (col),
        .rx_idle  (rx_idle)
    );

    mfa_tx_path #(.NIB_W(NIB_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_now  (mode_now),
        .tx_data   (tx_data),
        .tx_en     (tx_en),
        .tx_er     (tx_er),
        .enc_data  (enc_data),
        .enc_valid (enc_valid),
        .enc_err   (enc_err)
    );

endmodule

// File: rtl/phy_mac_port_chk.sv
// Checker for phy_mac_port: relates the port outputs to the link input
// and the held mode over time. Attached with the bind at the end.
module phy_mac_port_chk #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_up,
    input logic [NIB_W-1:0] rxd,
    input logic             rx_dv,
    input logic             rx_er,
    input logic             crs,
    input logic             col,
    input logic             enc_err,
    input logic             slow_q,
    input logic             five_q
);

    AST_QUIET_WITHOUT_CARRIER: assert property (@(negedge clk) disable iff (!rst_n)
        !crs |-> (rxd == '0 && !rx_dv)); // R1

    AST_LINK_FAIL_SILENT: assert property (@(negedge clk) disable iff (!rst_n)
        !link_up |=> (!crs && !rx_dv)); // R2

    AST_ERR_WITH_DATA: assert property (@(negedge clk) disable iff (!rst_n)
        (rx_er && !five_q) |-> rx_dv); // R3

    AST_SLOW_NO_RXER: assert property (@(negedge clk) disable iff (!rst_n)
        slow_q |-> !rx_er); // R4

    AST_SLOW_NO_TXER: assert property (@(negedge clk) disable iff (!rst_n)
        slow_q |-> !enc_err); // R4

    AST_DV_NEEDS_CRS: assert property (@(negedge clk) disable iff (!rst_n)
        rx_dv |-> crs); // R5

    AST_FIVE_NO_FRAMING: assert property (@(negedge clk) disable iff (!rst_n)
        five_q |-> (!rx_dv && !col && !enc_err)); // R7

    AST_MODE_HELD_IN_PACKET: assert property (@(negedge clk) disable iff (!rst_n)
        (rx_dv || (crs && !five_q)) |=> ($stable(slow_q) && $stable(five_q))); // R10

endmodule

bind phy_mac_port phy_mac_port_chk #(.NIB_W(NIB_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er),
    .crs     (crs),
    .col     (col),
    .enc_err (enc_err),
    .slow_q  (slow_q),
    .five_q  (five_q)
);

// File: tb/phy_mac_port_bench.sv
// Scoreboard bench: the driver applies inputs after a falling edge and
// queues the outputs expected after the next one; the monitor compares.
module phy_mac_port_bench;

    localparam int PERIOD = 10;

    typedef struct packed {
        logic       rstn, slow, byp, link, start, endp, err, lock, coll;
        logic [4:0] sym;
        logic [3:0] txd;
        logic       txen, txer;
    } in_t;

    typedef struct {
        logic [3:0] rxd;
        logic       dv, er, crs, col;
        logic [4:0] ed;
        logic       ev, ee;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n, sel_slow, sel_bypass, link_up, rx_start, rx_end;
    logic       rx_err, rx_lock, rx_coll, tx_en, tx_er;
    logic [4:0] rx_sym;
    logic [3:0] tx_data;
    logic [3:0] rxd;
    logic       rx_dv, rx_er, crs, col, enc_valid, enc_err;
    logic [4:0] enc_data;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    phy_mac_port u_phy_mac_port (
        .clk (clk), .rst_n (rst_n), .sel_slow (sel_slow), .sel_bypass (sel_bypass),
        .link_up (link_up), .rx_start (rx_start), .rx_end (rx_end), .rx_err (rx_err),
        .rx_lock (rx_lock), .rx_coll (rx_coll), .rx_sym (rx_sym), .tx_data (tx_data),
        .tx_en (tx_en), .tx_er (tx_er), .rxd (rxd), .rx_dv (rx_dv), .rx_er (rx_er),
        .crs (crs), .col (col), .enc_data (enc_data), .enc_valid (enc_valid),
        .enc_err (enc_err)
    );

    function automatic exp_t mk(logic [3:0] r, logic dv, logic er, logic cs, logic cl,
                                logic [4:0] ed, logic ev, logic ee, string tag);
        exp_t e;
        e.rxd = r; e.dv = dv; e.er = er; e.crs = cs; e.col = cl;
        e.ed = ed; e.ev = ev; e.ee = ee; e.tag = tag;
        return e;
    endfunction

    task automatic apply(input in_t i);
        rst_n = i.rstn; sel_slow = i.slow; sel_bypass = i.byp; link_up = i.link;
        rx_start = i.start; rx_end = i.endp; rx_err = i.err; rx_lock = i.lock;
        rx_coll = i.coll; rx_sym = i.sym; tx_data = i.txd; tx_en = i.txen; tx_er = i.txer;
    endtask

    task automatic step(input in_t i, input exp_t e);
        @(negedge clk);
        #2;
        apply(i);
        q.push_back(e);
    endtask

    task automatic compare(input exp_t e);
        logic [14:0] act, exp;
        act = {rxd, rx_dv, rx_er, crs, col, enc_data, enc_valid, enc_err};
        exp = {e.rxd, e.dv, e.er, e.crs, e.col, e.ed, e.ev, e.ee};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {rxd,dv,er,crs,col,enc_data,ev,ee} actual %h expected %h",
                     e.tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: compare outputs just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        in_t b, i;
        b = '0;
        b.rstn = 1'b1;
        b.link = 1'b1;
        i = b;
        i.rstn = 1'b0;
        apply(i);
        repeat (3) @(negedge clk);
        #1;
        compare(mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R12 reset state"));

        // 100 Mbit/s packet: R1, R13, R3, R11
        step(b, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R1 idle"));
        i = b; i.start = 1; i.sym = 5'h05;
        step(i, mk(4'h5, 1, 0, 1, 0, 5'h00, 0, 0, "R13 start edge carries data"));
        i = b; i.sym = 5'h0A;
        step(i, mk(4'hA, 1, 0, 1, 0, 5'h00, 0, 0, "R13 data"));
        i = b; i.sym = 5'h03; i.err = 1;
        step(i, mk(4'h3, 1, 1, 1, 0, 5'h00, 0, 0, "R3 error nibble"));
        i = b; i.sym = 5'h0C;
        step(i, mk(4'hC, 1, 0, 1, 0, 5'h00, 0, 0, "R3 error for one cycle only"));
        i = b; i.endp = 1; i.sym = 5'h0F;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R11 end drops all"));
        step(b, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R1 idle after packet"));

        // Link fail: R2
        i = b; i.start = 1; i.sym = 5'h01;
        step(i, mk(4'h1, 1, 0, 1, 0, 5'h00, 0, 0, "R13 start"));
        i = b; i.link = 0; i.sym = 5'h02;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R2 link lost mid-packet"));
        i = b; i.link = 0; i.start = 1; i.sym = 5'h06;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R2 start ignored on link fail"));
        step(b, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R1 idle after link returns"));

        // Collision: R9
        i = b; i.coll = 1;
        step(i, mk(4'h0, 0, 0, 0, 1, 5'h00, 0, 0, "R9 collision shown"));
        step(b, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R9 collision cleared"));

        // 10 Mbit/s: R4, R5, R10
        i = b; i.slow = 1; i.txen = 1; i.txd = 4'h7; i.txer = 1;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h07, 1, 0, "R4 tx_er ignored"));
        i = b; i.slow = 1; i.start = 1; i.sym = 5'h04;
        step(i, mk(4'h0, 0, 0, 1, 0, 5'h00, 0, 0, "R5 carrier before lock"));
        i = b; i.slow = 1; i.sym = 5'h05;
        step(i, mk(4'h0, 0, 0, 1, 0, 5'h00, 0, 0, "R5 still waiting for lock"));
        i = b; i.slow = 1; i.lock = 1; i.sym = 5'h06; i.err = 1;
        step(i, mk(4'h6, 1, 0, 1, 0, 5'h00, 0, 0, "R5 R4 data after lock, no rx_er"));
        i = b; i.slow = 0; i.lock = 1; i.sym = 5'h09; i.err = 1;
        step(i, mk(4'h9, 1, 0, 1, 0, 5'h00, 0, 0, "R10 speed held mid-packet"));
        i = b; i.endp = 1;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R11 end at 10 Mbit/s"));
        i = b; i.start = 1; i.sym = 5'h02; i.err = 1;
        step(i, mk(4'h2, 1, 1, 1, 0, 5'h00, 0, 0, "R10 new speed taken when idle"));
        i = b; i.endp = 1;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R11 end"));

        // Five-bit mode: R6, R7
        i = b; i.byp = 1; i.sym = 5'h1B; i.txd = 4'h6; i.txer = 1; i.coll = 1; i.start = 1;
        step(i, mk(4'hB, 0, 1, 1, 0, 5'h16, 1, 0, "R6 R7 symbol pass-through"));
        i = b; i.byp = 1; i.link = 0; i.sym = 5'h1F; i.txd = 4'h6; i.txer = 1; i.txen = 1;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h16, 1, 0, "R7 crs follows link"));
        i = b; i.byp = 1; i.sym = 5'h0A; i.txd = 4'h3;
        step(i, mk(4'hA, 0, 0, 1, 0, 5'h03, 1, 0, "R7 tx_en ignored"));

        // Bypass refused at 10 Mbit/s: R8
        i = b; i.byp = 1; i.slow = 1; i.start = 1; i.sym = 5'h14; i.err = 1;
        i.txen = 1; i.txd = 4'h5; i.txer = 1;
        step(i, mk(4'h0, 0, 0, 1, 0, 5'h05, 1, 0, "R8 nibble mode kept"));
        i = b; i.byp = 1; i.slow = 1; i.endp = 1; i.coll = 1;
        step(i, mk(4'h0, 0, 0, 0, 1, 5'h00, 0, 0, "R8 collision still valid"));

        // Transmit nibble mode: R13
        i = b; i.txen = 1; i.txd = 4'h9; i.txer = 1;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h09, 1, 1, "R13 tx error forwarded"));
        i = b; i.txd = 4'hF; i.txer = 1;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R13 tx disabled"));

        // Reset mid-packet: R12
        i = b; i.start = 1; i.sym = 5'h07;
        step(i, mk(4'h7, 1, 0, 1, 0, 5'h00, 0, 0, "R13 start"));
        i = b; i.rstn = 0; i.sym = 5'h08; i.txen = 1; i.txd = 4'h8;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R12 reset mid-packet"));
        i = b; i.sym = 5'h08;
        step(i, mk(4'h0, 0, 0, 0, 0, 5'h00, 0, 0, "R12 idle after reset"));

        repeat (3) @(negedge clk);
        #3;
        done = 1;
        summary();
        $finish;
    end

endmodule